// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the control unit for a small single-accumulator processor. It keeps the current phase of the instruction cycle in a 2-bit cycle code and steps a timing counter through t1, t2, ... within that phase. Each output is formed in combinational logic as a sum of products of three kinds of term: the phase, the decoded time step, and the decoded opcode. The outputs are gate enables that move data between the datapath registers (PC, MAR, MBR, IR, AC, the ALU input and output, and the stack pointer), plus the memory read and write strobes and an ALU function select.

The phases are fetch, indirect, execute and interrupt. Fetch loads the instruction and computes its operand address. The ALU has no direct path into the PC, so the PC increment goes through the accumulator, and fetch therefore takes four steps before the two operand steps. The phase that follows fetch is set by the indirect bit of the instruction. When execute ends, a pending interrupt with interrupts enabled starts the interrupt phase. That phase saves the PC through memory and loads the service address. The datapath, the memory and the ALU are outside this block.

Top module: `hwcu_ctrl`

## Requirements
- R1: While `rst_n` is low, every gate enable, `mem_rd`, `mem_wr` and `alu_fn` read 0. After the first clock edge with `rst_n` low, `cyc_code` reads 00 and `step_idx` reads 0. The first cycle after reset is fetch t1.
- R2: Cycle code values are fetch 00, indirect 01, execute 10 and interrupt 11. When fetch ends, the code becomes 01 if `ind_bit` is 1 in that last step, and 10 otherwise. When indirect ends, the code becomes 10.
- R3: Fetch lasts six steps. t1: gate 2. t2: gates 0, 5 and 14, `mem_rd`, `alu_fn`=1 (increment). t3: gates 4 and 9. t4: gate 15. t5: gate 16. t6: gates 0 and 5, `mem_rd`.
- R4: Indirect lasts two steps. t1: gate 8. t2: gates 0 and 5, `mem_rd`.
- R5: When execute ends, the code becomes 11 if `irq_req` and `irq_en` are both 1 in that last step, and 00 otherwise. A request with `irq_en` at 0 has no effect.
- R6: Interrupt lasts five steps. t1: gates 1 and 17. t2: gates 0 and 12, `mem_wr`. t3: gate 3. t4: gates 0 and 5, `mem_rd`. t5: gate 18. The code then returns to 00.
- R7: `step_idx` (0 means t1) restarts at 0 on every change of cycle code, and otherwise rises by one each clock. It never exceeds 5.
- R8: The execute phase for opcode 3 (add) lasts three steps. t1: gate 7. t2: gate 6, `alu_fn`=2 (add). t3: gate 9.
- R9: The execute phase for the other opcodes is as follows. Opcode 1 (load) takes one step with gate 10. Opcode 2 (store) takes two steps: gate 11, then gates 0 and 12 with `mem_wr`. Opcode 4 (jump) takes one step with gate 13. Any other opcode takes one step and asserts no outputs.
- R10: `mem_rd` and `mem_wr` are never high together. Gate 5 (bus into MBR) is never high in the same step as gate 4 (MBR to IR) or gate 12 (MBR onto the bus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | OP_W (3) | Opcode field from IR; held from fetch t4 through execute |
| ind_bit | input | 1 | Indirect-address bit of the current instruction |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| gate_en | output | 19 | Gate enables. Bit 0 MAR to address bus, 1 PC to MBR, 2 PC to MAR, 3 vector to MAR, 4 MBR to IR, 5 data bus to MBR, 6 AC to ALU, 7 MBR to ALU, 8 MBR to MAR, 9 ALU to AC, 10 MBR to AC, 11 AC to MBR, 12 MBR to data bus, 13 IR address to PC, 14 PC to ALU, 15 AC to PC, 16 IR address to MAR, 17 SP to MAR, 18 MBR to PC |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| alu_fn | output | 2 | ALU function: 0 none, 1 increment, 2 add |
| cyc_code | output | 2 | Current cycle code |
| step_idx | output | STEP_W (3) | Current time step, 0 means t1 |

## Verification
The assertions assume that `opcode` stays stable from the point where IR is loaded until the end of execute. The length of the execute phase and its outputs are decoded from `opcode` live, so a change during execute would cut the schedule short. The assertions also assume that all inputs are known values after reset. The stimulus changes `opcode` only in fetch t1. It drives `ind_bit`, `irq_req` and `irq_en` with fresh pseudo-random values every cycle, so the transition decisions meet every combination. A reset pulse in the middle of the run checks that reset forces the sequence back to fetch t1 from any phase.

// File: rtl/cu_pkg.sv
// Package: shared encodings for the hardwired control unit.
// Assumes: a single-accumulator datapath with the 19 gate points listed below.
package cu_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_t;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_INC  = 2'd1,
        ALU_ADD  = 2'd2
    } alu_t;

    // Gate positions on the gate_en vector
    localparam int G_MAR_ABUS = 0;
    localparam int G_PC_MBR   = 1;
    localparam int G_PC_MAR   = 2;
    localparam int G_VEC_MAR  = 3;
    localparam int G_MBR_IR   = 4;
    localparam int G_DBUS_MBR = 5;
    localparam int G_AC_ALU   = 6;
    localparam int G_MBR_ALU  = 7;
    localparam int G_MBR_MAR  = 8;
    localparam int G_ALU_AC   = 9;
    localparam int G_MBR_AC   = 10;
    localparam int G_AC_MBR   = 11;
    localparam int G_MBR_DBUS = 12;
    localparam int G_IRA_PC   = 13;
    localparam int G_PC_ALU   = 14;
    localparam int G_AC_PC    = 15;
    localparam int G_IRA_MAR  = 16;
    localparam int G_SP_MAR   = 17;
    localparam int G_MBR_PC   = 18;
    localparam int GATE_N     = 19;

    // Phase lengths in steps
    localparam int FETCH_STEPS = 6;
    localparam int INDIR_STEPS = 2;
    localparam int INTR_STEPS  = 5;
    localparam int MAX_STEPS   = 6;

    // Execute-phase opcodes with their own schedules
    localparam int XOP_N   = 4;
    localparam int X_LD    = 0;
    localparam int X_ST    = 1;
    localparam int X_ADD   = 2;
    localparam int X_JMP   = 3;
    localparam int XOP_CODE [XOP_N] = '{1, 2, 3, 4};
    localparam int XOP_LEN  [XOP_N] = '{1, 2, 3, 1};

endpackage

// File: rtl/cu_op_decode.sv
// Module: cu_op_decode
// Turns the opcode field into one line per scheduled execute opcode and
// gives the length of the execute phase for that opcode.
// Assumes: opcode is stable for the whole execute phase; undefined codes
// take a single empty step.
module cu_op_decode
    import cu_pkg::*;
#(
    parameter int OP_W   = 3,
    parameter int STEP_W = 3
) (
    input  logic [OP_W-1:0]   opcode,
    output logic [XOP_N-1:0]  op_line,
    output logic [STEP_W-1:0] exec_len
);

    // One comparator per scheduled opcode
    for (genvar k = 0; k < XOP_N; k++) begin : g_line
        assign op_line[k] = (opcode == OP_W'(XOP_CODE[k]));
    end

    // Length lookup; lines are mutually exclusive, default is one step
    always_comb begin
        exec_len = STEP_W'(1);
        for (int k = 0; k < XOP_N; k++) begin
            if (op_line[k]) exec_len = STEP_W'(XOP_LEN[k]);
        end
    end

endmodule

// File: rtl/cu_step_seq.sv
// Module: cu_step_seq
// Holds the cycle code and the time-step counter. On the step flagged as
// last the code takes the supplied next value and the counter restarts.
// Assumes: last_step is raised at or before step MAX_STEPS-1 in every phase.
module cu_step_seq
    import cu_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_step,
    input  cyc_t              next_cyc,
    output cyc_t              cyc_q,
    output logic [STEP_W-1:0] step_q
);

    // Phase and step registers with synchronous reset to fetch t1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CYC_FETCH;
            step_q <= '0;
        end else if (last_step) begin
            cyc_q  <= next_cyc;
            step_q <= '0;
        end else begin
            step_q <= step_q + STEP_W'(1);
        end
    end

    assert_step_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != $past(cyc_q)) |-> (step_q == '0));

    assert_step_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cyc_q == $past(cyc_q)) |-> (step_q == $past(step_q) + STEP_W'(1)));

    assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < STEP_W'(MAX_STEPS));

endmodule

// File: rtl/cu_ctrl_matrix.sv
// Module: cu_ctrl_matrix
// Sum-of-products control logic: decodes the time step, then ORs together
// phase/step/opcode terms for every gate, the strobes, the ALU select,
// the last-step flag and the next cycle code.
// Assumes: step_i stays below MAX_STEPS; op_line is at most one-hot.
module cu_ctrl_matrix
    import cu_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_t              cyc_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [XOP_N-1:0]  op_line,
    input  logic [STEP_W-1:0] exec_len,
    input  logic              ind_bit,
    input  logic              irq_req,
    input  logic              irq_en,
    output logic [GATE_N-1:0] gates,
    output logic              rd,
    output logic              wr,
    output alu_t              alu,
    output logic              last_step,
    output cyc_t              next_cyc
);

    logic [MAX_STEPS-1:0] t;
    logic ph_f, ph_i, ph_e, ph_r;
    logic x_ld, x_st, x_add, x_jmp;

    // Time-step decode, one line per step
    for (genvar k = 0; k < MAX_STEPS; k++) begin : g_tdec
        assign t[k] = (step_i == STEP_W'(k));
    end

    // Phase decode from the cycle code
    assign ph_f = (cyc_i == CYC_FETCH);
    assign ph_i = (cyc_i == CYC_INDIR);
    assign ph_e = (cyc_i == CYC_EXEC);
    assign ph_r = (cyc_i == CYC_INTR);

    // Execute terms qualified by phase
    assign x_ld  = ph_e & op_line[X_LD];
    assign x_st  = ph_e & op_line[X_ST];
    assign x_add = ph_e & op_line[X_ADD];
    assign x_jmp = ph_e & op_line[X_JMP];

    // Gate enables, one product sum per gate
    always_comb begin
        gates = '0;
        gates[G_MAR_ABUS] = (ph_f & (t[1] | t[5])) | (ph_i & t[1])
                          | (ph_r & (t[1] | t[3])) | (x_st & t[1]);
        gates[G_PC_MBR]   = ph_r & t[0];
        gates[G_PC_MAR]   = ph_f & t[0];
        gates[G_VEC_MAR]  = ph_r & t[2];
        gates[G_MBR_IR]   = ph_f & t[2];
        gates[G_DBUS_MBR] = (ph_f & (t[1] | t[5])) | (ph_i & t[1]) | (ph_r & t[3]);
        gates[G_AC_ALU]   = x_add & t[1];
        gates[G_MBR_ALU]  = x_add & t[0];
        gates[G_MBR_MAR]  = ph_i & t[0];
        gates[G_ALU_AC]   = (ph_f & t[2]) | (x_add & t[2]);
        gates[G_MBR_AC]   = x_ld & t[0];
        gates[G_AC_MBR]   = x_st & t[0];
        gates[G_MBR_DBUS] = (ph_r & t[1]) | (x_st & t[1]);
        gates[G_IRA_PC]   = x_jmp & t[0];
        gates[G_PC_ALU]   = ph_f & t[1];
        gates[G_AC_PC]    = ph_f & t[3];
        gates[G_IRA_MAR]  = ph_f & t[4];
        gates[G_SP_MAR]   = ph_r & t[0];
        gates[G_MBR_PC]   = ph_r & t[4];
    end

    // Memory strobes
    assign rd = (ph_f & (t[1] | t[5])) | (ph_i & t[1]) | (ph_r & t[3]);
    assign wr = (ph_r & t[1]) | (x_st & t[1]);

    // ALU function select
    always_comb begin
        if (ph_f & t[1])       alu = ALU_INC;
        else if (x_add & t[1]) alu = ALU_ADD;
        else                   alu = ALU_NONE;
    end

    // Last step of the current phase
    assign last_step = (ph_f & t[FETCH_STEPS-1]) | (ph_i & t[INDIR_STEPS-1])
                     | (ph_r & t[INTR_STEPS-1])
                     | (ph_e & (step_i == exec_len - STEP_W'(1)));

    // Next cycle code, used only on the last step
    always_comb begin
        unique case (cyc_i)
            CYC_FETCH: next_cyc = ind_bit ? CYC_INDIR : CYC_EXEC;
            CYC_INDIR: next_cyc = CYC_EXEC;
            CYC_EXEC:  next_cyc = (irq_req & irq_en) ? CYC_INTR : CYC_FETCH;
            default:   next_cyc = CYC_FETCH;
        endcase
    end

    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    assert_mbr_load_vs_ir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[G_DBUS_MBR] && gates[G_MBR_IR]));

    assert_mbr_load_vs_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[G_DBUS_MBR] && gates[G_MBR_DBUS]));

endmodule

// File: rtl/hwcu_ctrl.sv
// Module: hwcu_ctrl (top)
// Hardwired control unit: phase/step sequencer, opcode decode and control
// matrix. Control outputs are forced low while reset is held.
// Assumes: opcode stays stable from IR load through the end of execute.
module hwcu_ctrl
    import cu_pkg::*;
#(
    parameter int OP_W   = 3,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic              ind_bit,
    input  logic              irq_req,
    input  logic              irq_en,
    output logic [GATE_N-1:0] gate_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [1:0]        alu_fn,
    output logic [1:0]        cyc_code,
    output logic [STEP_W-1:0] step_idx
);

    cyc_t              cyc_q, next_cyc;
    logic [STEP_W-1:0] step_q, exec_len;
    logic [XOP_N-1:0]  op_line;
    logic [GATE_N-1:0] gates;
    logic              rd, wr, last_step;
    alu_t              alu;

    cu_step_seq #(.STEP_W(STEP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_step (last_step),
        .next_cyc  (next_cyc),
        .cyc_q     (cyc_q),
        .step_q    (step_q)
    );

    cu_op_decode #(.OP_W(OP_W), .STEP_W(STEP_W)) u_dec (
        .opcode   (opcode),
        .op_line  (op_line),
        .exec_len (exec_len)
    );

    cu_ctrl_matrix #(.STEP_W(STEP_W)) u_mtx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_i     (cyc_q),
        .step_i    (step_q),
        .op_line   (op_line),
        .exec_len  (exec_len),
        .ind_bit   (ind_bit),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .gates     (gates),
        .rd        (rd),
        .wr        (wr),
        .alu       (alu),
        .last_step (last_step),
        .next_cyc  (next_cyc)
    );

    // Output masking during reset
    assign gate_en  = rst_n ? gates : '0;
    assign mem_rd   = rst_n & rd;
    assign mem_wr   = rst_n & wr;
    assign alu_fn   = rst_n ? alu : ALU_NONE;
    assign cyc_code = cyc_q;
    assign step_idx = step_q;

    assert_fetch_to_indir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_FETCH && last_step && ind_bit) |=> (cyc_q == CYC_INDIR));

    assert_exec_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_EXEC && last_step && !(irq_req && irq_en)) |=> (cyc_q == CYC_FETCH));

    assert_intr_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_INTR && last_step) |=> (cyc_q == CYC_FETCH));

endmodule

// File: tb/hwcu_ctrl_test.sv
module hwcu_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int GN         = 19;
    localparam int RUN_CYCLES = 4000;
    localparam int WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    opcode = 3'd0;
    logic          ind_bit = 1'b0, irq_req = 1'b0, irq_en = 1'b0;
    logic [GN-1:0] gate_en;
    logic          mem_rd, mem_wr;
    logic [1:0]    alu_fn, cyc_code;
    logic [2:0]    step_idx;

    int  n_tests = 0, n_fail = 0;
    bit  done = 0;

    // Reference model state
    int  m_cyc = 0, m_step = 0;
    string m_code_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    hwcu_ctrl uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ind_bit(ind_bit),
        .irq_req(irq_req), .irq_en(irq_en), .gate_en(gate_en),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_fn(alu_fn),
        .cyc_code(cyc_code), .step_idx(step_idx)
    );

    // Expected gates from the schedules in R3, R4, R6, R8, R9
    function automatic logic [GN-1:0] exp_gates(int cyc, int st, int op);
        logic [GN-1:0] g = '0;
        if (cyc == 0) begin
            if (st == 0) g[2] = 1;
            if (st == 1) begin g[0] = 1; g[5] = 1; g[14] = 1; end
            if (st == 2) begin g[4] = 1; g[9] = 1; end
            if (st == 3) g[15] = 1;
            if (st == 4) g[16] = 1;
            if (st == 5) begin g[0] = 1; g[5] = 1; end
        end else if (cyc == 1) begin
            if (st == 0) g[8] = 1;
            if (st == 1) begin g[0] = 1; g[5] = 1; end
        end else if (cyc == 2) begin
            if (op == 1 && st == 0) g[10] = 1;
            if (op == 2 && st == 0) g[11] = 1;
            if (op == 2 && st == 1) begin g[12] = 1; g[0] = 1; end
            if (op == 3 && st == 0) g[7] = 1;
            if (op == 3 && st == 1) g[6] = 1;
            if (op == 3 && st == 2) g[9] = 1;
            if (op == 4 && st == 0) g[13] = 1;
        end else begin
            if (st == 0) begin g[1] = 1; g[17] = 1; end
            if (st == 1) begin g[12] = 1; g[0] = 1; end
            if (st == 2) g[3] = 1;
            if (st == 3) begin g[5] = 1; g[0] = 1; end
            if (st == 4) g[18] = 1;
        end
        return g;
    endfunction

    function automatic int phase_len(int cyc, int op);
        if (cyc == 0) return 6;
        if (cyc == 1) return 2;
        if (cyc == 3) return 5;
        if (op == 2) return 2;
        if (op == 3) return 3;
        return 1;
    endfunction

    function automatic string sched_tag(int cyc, int op);
        if (cyc == 0) return "R3";
        if (cyc == 1) return "R4";
        if (cyc == 3) return "R6";
        if (op == 3) return "R8";
        return "R9";
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model (called away from the clock edge)
    task automatic compare_all();
        logic [GN-1:0] eg;
        int op = int'(opcode);
        int erd, ewr, ealu;
        string tg;
        if (!rst_n) begin
            check("R1", "gates in reset", int'(gate_en), 0);
            check("R1", "strobes in reset", int'({mem_rd, mem_wr}), 0);
            check("R1", "alu in reset", int'(alu_fn), 0);
            check("R1", "code in reset", int'(cyc_code), 0);
            check("R1", "step in reset", int'(step_idx), 0);
            return;
        end
        eg   = exp_gates(m_cyc, m_step, op);
        tg   = sched_tag(m_cyc, op);
        erd  = ((m_cyc == 0 && (m_step == 1 || m_step == 5)) || (m_cyc == 1 && m_step == 1)
                || (m_cyc == 3 && m_step == 3)) ? 1 : 0;
        ewr  = ((m_cyc == 3 && m_step == 1) || (m_cyc == 2 && op == 2 && m_step == 1)) ? 1 : 0;
        ealu = (m_cyc == 0 && m_step == 1) ? 1 : (m_cyc == 2 && op == 3 && m_step == 1) ? 2 : 0;
        check(tg, "gate_en", int'(gate_en), int'(eg));
        check(tg, "mem_rd", int'(mem_rd), erd);
        check(tg, "mem_wr", int'(mem_wr), ewr);
        check(tg, "alu_fn", int'(alu_fn), ealu);
        check(m_code_tag, "cyc_code", int'(cyc_code), m_cyc);
        check("R7", "step_idx", int'(step_idx), m_step);
        check("R10", "rd/wr exclusive", int'(mem_rd & mem_wr), 0);
        check("R10", "MBR load vs IR/drive", int'(gate_en[5] & (gate_en[4] | gate_en[12])), 0);
    endtask

    // Advance the model across the next clock edge using the driven inputs
    task automatic advance_model();
        int op = int'(opcode);
        if (!rst_n) begin
            m_cyc = 0; m_step = 0; m_code_tag = "R1";
            return;
        end
        if (m_step == phase_len(m_cyc, op) - 1) begin
            case (m_cyc)
                0: begin m_cyc = ind_bit ? 1 : 2; m_code_tag = "R2"; end
                1: begin m_cyc = 2; m_code_tag = "R2"; end
                2: begin m_cyc = (irq_req && irq_en) ? 3 : 0; m_code_tag = "R5"; end
                default: begin m_cyc = 0; m_code_tag = "R6"; end
            endcase
            m_step = 0;
        end else begin
            m_step++;
        end
    endtask

    initial begin
        int op_sel = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < RUN_CYCLES; c++) begin
            @(negedge clk);
            compare_all();
            // drive inputs for the next edge
            rst_n = !(c < 2 || (c >= 1500 && c < 1503));
            ind_bit = 1'($urandom_range(0, 1));
            irq_req = 1'($urandom_range(0, 1));
            irq_en  = 1'($urandom_range(0, 1));
            if (m_cyc == 0 && m_step == 0) begin
                opcode = 3'(op_sel);
                op_sel = (op_sel + 1) % 8;
            end
            advance_model();
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule